// File: doc/BRIEF.md
# Split-Mode Event Counter Unit

This block counts hardware events in four physical counters behind a small word-addressed register port. Each physical counter can run as one 32-bit counter or be split into two 16-bit halves that count independently. This gives software eight logical counters. Each half or full counter advances by one in every cycle in which the unit is enabled and its event input is high. When a counter wraps from all ones to zero, it raises a sticky flag. The interrupt line combines those flags with a per-flag enable mask.

Software never writes a running counter directly. A counter write lands in a per-counter holding latch and marks it pending. The pending value moves into the live counter only when the control register is written with the enable bit set. That covers both the first enable and a rewrite while the unit is already running. Reading the status register reports and clears the flags in one access. Register reads return their data one cycle after the request.

Top module: `perfctr_unit`

## Requirements
- R1: After reset the control word, interrupt mask, flags, all counters, all latches and `rdata_o` are zero, and `irq_o` is low.
- R2: The control register sits at word 0. Bit 0 is the global enable. Bits 4 to 7 are the split bits for physical counters 0 to 3; a set bit selects two 16-bit halves. All other bits read back as zero.
- R3: Logical counters 0 to 7 sit at words 8 to 15. Logical index k selects physical counter k mod 4. In split mode, index k < 4 is the upper half and k >= 4 is the lower half. A read returns only that half, zero-extended. A write replaces only that half; the other half is taken from the latch if one is pending, otherwise from the live count. In 32-bit mode, k and k+4 both address the full counter.
- R4: A counter write changes only that counter's latch and marks it pending. While enable is clear, reading a pending counter returns the latched value. While enable is set, reads return the live count.
- R5: Any control write with bit 0 set loads every pending latch into its live counter and clears the pending marks, whether enable was clear or already set. A counter loaded this way does not count in that cycle.
- R6: While enable is set, event input n adds one to physical counter n in 32-bit mode, and event input n+4 is ignored. In split mode, event n drives the upper half and event n+4 drives the lower half. Each half wraps on its own with no carry between them.
- R7: While enable is clear, live counts do not change. Latches stay pending until the next commit.
- R8: A wrap from all ones to zero sets flag n for a 32-bit counter n or the upper half of split counter n. It sets flag n+4 for the lower half of split counter n.
- R9: A read of word 1 returns the mask in bits 15:8 and the flags in bits 7:0, and clears the flags. A wrap in that same cycle still sets its flag.
- R10: A write to word 1 loads the mask from bits 7:0; writing zero disables every interrupt. `irq_o` is high exactly when some flag and its mask bit are both set.
- R11: Read data appears on `rdata_o` in the cycle after `rd_en_i` and holds until the next read. Words 2 to 7 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| event_i | input | 8 | Per-logical-counter event inputs |
| irq_o | output | 1 | Counter-wrap interrupt |

## Verification
The hardest case to reach from the ports is a counter sitting a few counts below a wrap while a commit, a mode change, a status read or a half-write merge lands in the same window. The bench therefore loads the counters through the latch-and-commit path, seeding values just below a 16-bit or 32-bit boundary. It then mixes random enable rewrites, split-bit changes and dense event patterns, so wraps collide with commits and with read-to-clear accesses. Directed steps first cover each of these collisions in isolation.

// File: rtl/perfctr_pkg.sv
`timescale 1ns/1ps
package perfctr_pkg;
    // word addresses of the two control words; counters live in the upper half of the map
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    // control word layout
    localparam int EN_BIT    = 0;
    localparam int SPLIT_LSB = 4;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_STAT,
        ACC_CNT
    } acc_e;
endpackage

// File: rtl/perfctr_slice.sv
`timescale 1ns/1ps
module perfctr_slice #(
    parameter int CW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          split_i,
    input  logic          en_i,
    input  logic          commit_i,
    input  logic          wr_i,
    input  logic          wr_upper_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          ev_hi_i,
    input  logic          ev_lo_i,
    output logic [CW-1:0] view_o,
    output logic [CW-1:0] live_o,
    output logic          pend_o,
    output logic          wrap_hi_o,
    output logic          wrap_lo_o
);
    localparam int HW = CW / 2;

    typedef struct packed {
        logic [CW-1:0] live;
        logic [CW-1:0] latch;
        logic          pend;
    } slice_t;

    slice_t        s_q, s_d;
    logic [CW-1:0] base_w, merged_w, counted_w;
    logic [HW-1:0] hi_cur, lo_cur, hi_nxt, lo_nxt;
    logic          inc_hi, inc_lo;

    always_comb begin
        inc_hi = en_i & ev_hi_i;
        inc_lo = en_i & ev_lo_i;
        hi_cur = s_q.live[CW-1:HW];
        lo_cur = s_q.live[HW-1:0];
        hi_nxt = hi_cur + {{(HW-1){1'b0}}, inc_hi};
        lo_nxt = lo_cur + {{(HW-1){1'b0}}, inc_lo};

        // counting path: halves are independent in split mode
        if (split_i) begin
            counted_w = {hi_nxt, lo_nxt};
            wrap_hi_o = inc_hi & (&hi_cur);
            wrap_lo_o = inc_lo & (&lo_cur);
        end else begin
            counted_w = s_q.live + {{(CW-1){1'b0}}, inc_hi};
            wrap_hi_o = inc_hi & (&s_q.live);
            wrap_lo_o = 1'b0;
        end

        // merge base for a half-width write: newest known value
        base_w = s_q.pend ? s_q.latch : s_q.live;
        if (!split_i) begin
            merged_w = wdata_i;
        end else if (wr_upper_i) begin
            merged_w = {wdata_i[HW-1:0], base_w[HW-1:0]};
        end else begin
            merged_w = {base_w[CW-1:HW], wdata_i[HW-1:0]};
        end

        s_d = s_q;
        if (commit_i && s_q.pend) begin
            s_d.live  = s_q.latch;
            s_d.pend  = 1'b0;
            wrap_hi_o = 1'b0;
            wrap_lo_o = 1'b0;
        end else begin
            s_d.live = counted_w;
        end
        if (wr_i) begin
            s_d.latch = merged_w;
            s_d.pend  = 1'b1;
        end

        view_o = (s_q.pend && !en_i) ? s_q.latch : s_q.live;
        live_o = s_q.live;
        pend_o = s_q.pend;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/perfctr_readmux.sv
`timescale 1ns/1ps
module perfctr_readmux
    import perfctr_pkg::*;
#(
    parameter int NPHYS = 4,
    parameter int CW    = 32,
    parameter int NLOG  = 2 * NPHYS,
    parameter int AW    = $clog2(NLOG) + 1
) (
    input  logic [AW-1:0]             addr_i,
    input  logic [CW-1:0]             ctrl_i,
    input  logic [NLOG-1:0]           mask_i,
    input  logic [NLOG-1:0]           flags_i,
    input  logic [NPHYS-1:0][CW-1:0]  view_i,
    input  logic [NPHYS-1:0]          split_i,
    output logic [CW-1:0]             value_o
);
    localparam int PW = $clog2(NPHYS);
    localparam int IW = AW - 1;
    localparam int HW = CW / 2;

    logic [IW-1:0] idx;
    logic [PW-1:0] phys;
    logic [CW-1:0] pv;

    always_comb begin
        idx     = addr_i[IW-1:0];
        phys    = idx[PW-1:0];
        pv      = view_i[phys];
        value_o = '0;
        if (addr_i[AW-1]) begin
            if (split_i[phys]) begin
                value_o = idx[PW] ? {{HW{1'b0}}, pv[HW-1:0]}
                                  : {{HW{1'b0}}, pv[CW-1:HW]};
            end else begin
                value_o = pv;
            end
        end else if (addr_i == AW'(ADDR_CTRL)) begin
            value_o = ctrl_i;
        end else if (addr_i == AW'(ADDR_STAT)) begin
            value_o = CW'({mask_i, flags_i});
        end
    end
endmodule

// File: rtl/perfctr_unit.sv
`timescale 1ns/1ps
module perfctr_unit
    import perfctr_pkg::*;
#(
    parameter int NPHYS = 4,
    parameter int CW    = 32,
    parameter int NLOG  = 2 * NPHYS,
    parameter int AW    = $clog2(NLOG) + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  logic            rd_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [CW-1:0]   wdata_i,
    output logic [CW-1:0]   rdata_o,
    input  logic [NLOG-1:0] event_i,
    output logic            irq_o
);
    localparam int PW = $clog2(NPHYS);
    localparam int IW = AW - 1;
    localparam logic [CW-1:0] CTRL_MASK =
        (((CW'(1) << NPHYS) - CW'(1)) << SPLIT_LSB) | (CW'(1) << EN_BIT);

    typedef struct packed {
        logic [CW-1:0]   ctrl;
        logic [NLOG-1:0] mask;
        logic [NLOG-1:0] flags;
        logic [CW-1:0]   rdata;
    } regs_t;

    regs_t                    r_q, r_d;
    acc_e                     sel;
    logic                     run_en, commit, wr_cnt;
    logic [NPHYS-1:0]         split;
    logic [IW-1:0]            cnt_idx;
    logic [NPHYS-1:0][CW-1:0] view_arr, live_arr;
    logic [NPHYS-1:0]         pend_vec, wrap_hi, wrap_lo;
    logic [NLOG-1:0]          wrap_vec;
    logic [CW-1:0]            rd_val;

    always_comb begin
        if (addr_i[AW-1])                     sel = ACC_CNT;
        else if (addr_i == AW'(ADDR_CTRL))    sel = ACC_CTRL;
        else if (addr_i == AW'(ADDR_STAT))    sel = ACC_STAT;
        else                                  sel = ACC_NONE;
    end

    assign run_en   = r_q.ctrl[EN_BIT];
    assign split    = r_q.ctrl[SPLIT_LSB +: NPHYS];
    assign commit   = wr_en_i && (sel == ACC_CTRL) && wdata_i[EN_BIT];
    assign wr_cnt   = wr_en_i && (sel == ACC_CNT);
    assign cnt_idx  = addr_i[IW-1:0];
    assign wrap_vec = {wrap_lo, wrap_hi};

    for (genvar n = 0; n < NPHYS; n++) begin : g_slice
        perfctr_slice #(.CW(CW)) u_slice (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .split_i    (split[n]),
            .en_i       (run_en),
            .commit_i   (commit),
            .wr_i       (wr_cnt && (cnt_idx[PW-1:0] == PW'(n))),
            .wr_upper_i (!cnt_idx[PW]),
            .wdata_i    (wdata_i),
            .ev_hi_i    (event_i[n]),
            .ev_lo_i    (event_i[n+NPHYS]),
            .view_o     (view_arr[n]),
            .live_o     (live_arr[n]),
            .pend_o     (pend_vec[n]),
            .wrap_hi_o  (wrap_hi[n]),
            .wrap_lo_o  (wrap_lo[n])
        );
    end

    perfctr_readmux #(.NPHYS(NPHYS), .CW(CW), .NLOG(NLOG), .AW(AW)) u_rdmux (
        .addr_i  (addr_i),
        .ctrl_i  (r_q.ctrl),
        .mask_i  (r_q.mask),
        .flags_i (r_q.flags),
        .view_i  (view_arr),
        .split_i (split),
        .value_o (rd_val)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en_i && sel == ACC_CTRL) r_d.ctrl = wdata_i & CTRL_MASK;
        if (wr_en_i && sel == ACC_STAT) r_d.mask = wdata_i[NLOG-1:0];
        // read-to-clear first, fresh wraps win
        r_d.flags = ((rd_en_i && sel == ACC_STAT) ? '0 : r_q.flags) | wrap_vec;
        if (rd_en_i) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata_o = r_q.rdata;
    assign irq_o   = |(r_q.flags & r_q.mask);
endmodule

// File: rtl/perfctr_unit_sva.sv
`timescale 1ns/1ps
module perfctr_unit_sva #(
    parameter int NPHYS = 4,
    parameter int CW    = 32,
    parameter int AW    = 4
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     wr_en_i,
    input logic                     rd_en_i,
    input logic [AW-1:0]            addr_i,
    input logic [CW-1:0]            wdata_i,
    input logic [CW-1:0]            rdata_o,
    input logic                     irq_o,
    input logic                     run_en,
    input logic [NPHYS-1:0][CW-1:0] live_arr,
    input logic [NPHYS-1:0]         pend_vec
);
    logic ctrl_wr_go, cnt_wr, stat_wr_zero, stat_rd;

    assign ctrl_wr_go   = wr_en_i && (addr_i == AW'(0)) && wdata_i[0];
    assign cnt_wr       = wr_en_i && addr_i[AW-1];
    assign stat_wr_zero = wr_en_i && (addr_i == AW'(1)) && (wdata_i[2*NPHYS-1:0] == '0);
    assign stat_rd      = rd_en_i && (addr_i == AW'(1));

    assert_latch_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_en && cnt_wr) |=> $stable(live_arr));

    assert_commit_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr_go |=> (pend_vec == '0));

    assert_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_en && !ctrl_wr_go) |=> $stable(live_arr));

    assert_clear_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_rd && !run_en) |=> !irq_o);

    assert_mask_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_wr_zero |=> !irq_o);

    assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));
endmodule

bind perfctr_unit perfctr_unit_sva #(.NPHYS(NPHYS), .CW(CW), .AW(AW)) u_sva (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .run_en   (run_en),
    .live_arr (live_arr),
    .pend_vec (pend_vec)
);

// File: tb/perfctr_unit_bench.sv
`timescale 1ns/1ps
module perfctr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  ev = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    // reference state built from the requirements
    logic [31:0] m_live [4];
    logic [31:0] m_latch[4];
    logic        m_pend [4];
    logic [31:0] m_ctrl, m_rdata;
    logic [7:0]  m_mask, m_flags;

    always #10 clk = ~clk;

    perfctr_unit u_perfctr_unit (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] view(input int p);
        return (m_pend[p] && !m_ctrl[0]) ? m_latch[p] : m_live[p];
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        int k, p;
        logic [31:0] v;
        if (a[3]) begin
            k = int'(a[2:0]);
            p = k % 4;
            v = view(p);
            if (m_ctrl[4+p]) return (k < 4) ? {16'h0, v[31:16]} : {16'h0, v[15:0]};
            return v;
        end
        if (a == 4'd0) return m_ctrl;
        if (a == 4'd1) return {16'h0, m_mask, m_flags};
        return 32'h0;
    endfunction

    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [31:0] d, input logic [7:0] e, input string tag);
        logic [31:0] nl[4];
        logic [31:0] nla[4];
        logic        np[4];
        logic [7:0]  nf;
        logic [31:0] base, exp_rd;
        logic [15:0] hi, lo;
        logic        commit;
        wr_en = w; rd_en = r; addr = a; wdata = d; ev = e;
        exp_rd = r ? model_read(a) : m_rdata;
        commit = w && (a == 4'd0) && d[0];
        nf = (r && a == 4'd1) ? 8'h0 : m_flags;
        for (int p = 0; p < 4; p++) begin
            nl[p] = m_live[p]; nla[p] = m_latch[p]; np[p] = m_pend[p];
            if (commit && m_pend[p]) begin
                nl[p] = m_latch[p]; np[p] = 1'b0;
            end else if (m_ctrl[0]) begin
                if (m_ctrl[4+p]) begin
                    hi = m_live[p][31:16]; lo = m_live[p][15:0];
                    if (e[p])   begin if (hi == 16'hFFFF) nf[p]   = 1'b1; hi = hi + 16'd1; end
                    if (e[p+4]) begin if (lo == 16'hFFFF) nf[p+4] = 1'b1; lo = lo + 16'd1; end
                    nl[p] = {hi, lo};
                end else if (e[p]) begin
                    if (m_live[p] == 32'hFFFF_FFFF) nf[p] = 1'b1;
                    nl[p] = m_live[p] + 32'd1;
                end
            end
            if (w && a[3] && (int'(a[1:0]) == p)) begin
                base = m_pend[p] ? m_latch[p] : m_live[p];
                if (!m_ctrl[4+p])  nla[p] = d;
                else if (!a[2])    nla[p] = {d[15:0], base[15:0]};
                else               nla[p] = {base[31:16], d[15:0]};
                np[p] = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            m_live[p] = nl[p]; m_latch[p] = nla[p]; m_pend[p] = np[p];
        end
        m_flags = nf;
        if (w && a == 4'd0) m_ctrl = d & 32'h0000_00F1;
        if (w && a == 4'd1) m_mask = d[7:0];
        m_rdata = exp_rd;
        chk(r ? tag : "R11", rdata, m_rdata);
        chk("R10", {31'h0, irq}, {31'h0, |(m_flags & m_mask)});
        wr_en = 0; rd_en = 0; ev = '0;
    endtask

    task automatic idle(input int n, input logic [7:0] e);
        for (int i = 0; i < n; i++) cyc(0, 0, 4'd0, 32'h0, e, "R6");
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed, k;
        logic [31:0] v;
        seed = $urandom(32'd7781);
        for (int p = 0; p < 4; p++) begin m_live[p] = 0; m_latch[p] = 0; m_pend[p] = 0; end
        m_ctrl = 0; m_rdata = 0; m_mask = 0; m_flags = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", rdata, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);
        cyc(0, 1, 4'd0, 0, 0, "R1");
        cyc(0, 1, 4'd1, 0, 0, "R1");
        cyc(0, 1, 4'd9, 0, 0, "R1");
        // R4 latch while disabled, R5 commit on enable, R6 counting
        cyc(1, 0, 4'd8, 32'h1234_5678, 0, "R4");
        cyc(0, 1, 4'd8, 0, 0, "R4");
        cyc(1, 0, 4'd0, 32'hFFFF_FF01, 8'h01, "R5");
        cyc(0, 1, 4'd0, 0, 0, "R2");
        idle(5, 8'hF1);
        cyc(0, 1, 4'd8, 0, 0, "R6");
        // R4 write while enabled stays latched, R5 rewrite commits
        cyc(1, 0, 4'd8, 32'h0000_0100, 8'h01, "R4");
        cyc(0, 1, 4'd8, 0, 8'h01, "R4");
        cyc(1, 0, 4'd0, 32'h1, 8'h01, "R5");
        cyc(0, 1, 4'd8, 0, 0, "R5");
        // R7 freeze, pending survives
        cyc(1, 0, 4'd0, 32'h0, 0, "R7");
        idle(3, 8'hFF);
        cyc(1, 0, 4'd9, 32'h55, 0, "R7");
        idle(2, 8'hFF);
        cyc(0, 1, 4'd9, 0, 0, "R7");
        cyc(0, 1, 4'd8, 0, 0, "R7");
        // R3 split halves
        cyc(1, 0, 4'd0, 32'h10, 0, "R3");
        cyc(1, 0, 4'd8, 32'h0000_AAAA, 0, "R3");
        cyc(1, 0, 4'd12, 32'hBEEF_5555, 0, "R3");
        cyc(0, 1, 4'd8, 0, 0, "R3");
        cyc(0, 1, 4'd12, 0, 0, "R3");
        // R8 wraps in split mode with mask set, R9 read-to-clear
        cyc(1, 0, 4'd8, 32'hFFFF, 0, "R8");
        cyc(1, 0, 4'd12, 32'hFFFE, 0, "R8");
        cyc(1, 0, 4'd1, 32'hFF, 0, "R10");
        cyc(1, 0, 4'd0, 32'h11, 0, "R5");
        cyc(0, 0, 4'd0, 0, 8'h11, "R8");
        cyc(0, 1, 4'd12, 0, 8'h10, "R8");
        cyc(0, 1, 4'd1, 0, 0, "R9");
        cyc(0, 1, 4'd1, 0, 0, "R9");
        cyc(0, 0, 4'd0, 0, 8'h10, "R8");
        cyc(0, 1, 4'd1, 0, 8'h10, "R9");
        cyc(0, 1, 4'd1, 0, 0, "R9");
        // R10 mask zero silences a raised flag
        cyc(1, 0, 4'd1, 32'h0, 0, "R10");
        cyc(0, 1, 4'd1, 0, 0, "R10");
        // R6/R8 32-bit wrap, event n+4 ignored
        cyc(1, 0, 4'd0, 32'h1, 0, "R6");
        cyc(1, 0, 4'd9, 32'hFFFF_FFFF, 0, "R8");
        cyc(1, 0, 4'd0, 32'h1, 0, "R5");
        cyc(1, 0, 4'd1, 32'h02, 8'h20, "R6");
        cyc(0, 1, 4'd13, 0, 8'h02, "R8");
        cyc(0, 1, 4'd1, 0, 0, "R8");
        // R11 unmapped words
        cyc(1, 0, 4'd5, 32'hFFFF_FFFF, 0, "R11");
        cyc(0, 1, 4'd5, 0, 0, "R11");
        cyc(0, 1, 4'd0, 0, 0, "R11");
        idle(2, 0);
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] e;
            k = $urandom_range(0, 99);
            e = (k % 7 == 0) ? 8'hFF : 8'($urandom & $urandom);
            case ($urandom_range(0, 3))
                0:       v = $urandom;
                1:       v = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
                2:       v = 32'hFFF8_FFF8 | 32'($urandom_range(0, 7));
                default: v = 32'h0000_FFF8 | 32'($urandom_range(0, 7));
            endcase
            if (k < 50)      cyc(0, 0, 4'd0, 0, e, "R6");
            else if (k < 65) cyc(0, 1, 4'(8 + $urandom_range(0, 7)), 0, e, "R3");
            else if (k < 73) cyc(0, 1, 4'd1, 0, e, "R9");
            else if (k < 77) cyc(0, 1, 4'd0, 0, e, "R2");
            else if (k < 87) cyc(1, 0, 4'(8 + $urandom_range(0, 7)), v, e, "R4");
            else if (k < 94) cyc(1, 0, 4'd0,
                                 ($urandom & 32'hFFFF_FFFE) | 32'($urandom_range(0, 3) != 0), e, "R5");
            else if (k < 98) cyc(1, 0, 4'd1, ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom, e, "R10");
            else             cyc(k[0], !k[0], 4'(2 + $urandom_range(0, 5)), $urandom, e, "R11");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule